// File: doc/BRIEF.md
# NOR Flash Write-Status Read Generator

This block produces what a host sees on the read data bus of a NOR flash while an internal program or erase is in progress. A command decoder elsewhere sends it a start pulse once the last write of a command sequence has landed: a program start carries the word being written, and an erase start carries the erase scope (sector, block or whole chip). An internal timer then holds the block busy for a parameterised number of clock cycles that depends on the operation.

While the block is busy, it replaces the array read data with status. Bit 7 is a polling bit: it reads as the inverse of bit 7 of the programmed word during a program, and as 0 during an erase. Bit 6 flips on every read strobe. Every other bit reads as 1. When the timer expires, the block pulses `done` for one cycle. For a settling window after that, only bit 7 carries array data and the other bits still read as 1. After the window, array data passes through unchanged.

Start pulses that arrive while the block is busy are dropped. If a program start and an erase start arrive in the same cycle, the program start wins.

Top module: `nor_wstatus`

## Requirements
- R1: A start pulse (`start_prog` or `start_erase`) seen while idle makes `busy` high from the next cycle, and status replaces read data from that same cycle.
- R2: `busy` stays high for exactly PROG_CYC cycles for a program. An erase uses `erase_kind`: code 0 selects sector (SECT_CYC cycles), code 1 selects block (BLK_CYC cycles), and codes 2 and 3 select whole chip (CHIP_CYC cycles).
- R3: `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R4: During a program, `rd_q[7]` is the inverse of bit 7 of the word captured at the start.
- R5: During any erase, `rd_q[7]` is 0.
- R6: After a start, `rd_q[6]` reads 0. It inverts once for each read strobe taken while busy. A read strobe is a high-to-low change of `oe_n`, sampled on the clock, while `ce_n` is low. A falling `oe_n` while `ce_n` is high does not change `rd_q[6]`.
- R7: While busy, every bit of `rd_q` other than bits 7 and 6 reads 1.
- R8: For SETTLE_CYC cycles after `busy` falls, `rd_q[7]` equals `array_q[7]` and every other bit reads 1.
- R9: When the block is neither busy nor settling, `rd_q` equals `array_q`.
- R10: Start pulses that arrive while busy have no effect: the running operation keeps its length and its polling value.
- R11: When `start_prog` and `start_erase` arrive in the same cycle while idle, a program of PROG_CYC cycles runs.
- R12: After reset, `busy` and `done` are 0 and `rd_q` equals `array_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_prog | input | 1 | One-cycle pulse that starts a program |
| prog_word | input | DW | Word being programmed, captured with `start_prog` |
| start_erase | input | 1 | One-cycle pulse that starts an erase |
| erase_kind | input | 2 | Erase scope: 0 sector, 1 block, 2 or 3 whole chip |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low; its falling edge is a read strobe |
| array_q | input | DW | Data read from the storage array |
| rd_q | output | DW | Read data as seen by the host |
| busy | output | 1 | High while an internal operation runs |
| done | output | 1 | One-cycle pulse when an operation finishes |

## Verification
The bench measures the busy interval for every operation kind, including the shared chip encoding and simultaneous starts. A timer that is off by one cycle shows up as a count mismatch, and a wrong priority shows up as an erase-length run where a program run was expected. It drives an `oe_n` fall with `ce_n` high between genuine strobes; a design that ignores chip select would flip bit 6 one time too many. It also fires a start with a different word in the middle of a busy interval. A design that re-latches on that pulse would flip the polling bit or restart the timer. Finally, the bench checks the edges of the settling window, where a design that releases the bus early or late shows array bits one cycle off.

// File: rtl/nws_pkg.sv
package nws_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  // program start takes priority; erase scope codes 2 and 3 both mean chip
  function automatic op_e pick_op(input logic sp, input logic [1:0] ek);
    if (sp) return OP_PROG;
    case (ek)
      2'd0:    return OP_SECT;
      2'd1:    return OP_BLK;
      default: return OP_CHIP;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/nws_timer.sv
module nws_timer
  import nws_pkg::*;
#(
  parameter int unsigned PROG_CYC   = 24,
  parameter int unsigned SECT_CYC   = 60,
  parameter int unsigned BLK_CYC    = 75,
  parameter int unsigned CHIP_CYC   = 110,
  parameter int unsigned SETTLE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  op_e  op,
  output logic busy,
  output logic done,
  output logic settling
);
  localparam int unsigned MAXC = max4(PROG_CYC, SECT_CYC, BLK_CYC, CHIP_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt;
  logic [SW-1:0] settle_cnt;

  function automatic logic [CW-1:0] len_of(input op_e o);
    case (o)
      OP_PROG: return CW'(PROG_CYC);
      OP_SECT: return CW'(SECT_CYC);
      OP_BLK:  return CW'(BLK_CYC);
      default: return CW'(CHIP_CYC);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      cnt        <= '0;
      settle_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy       <= 1'b0;
          done       <= 1'b1;
          settle_cnt <= SW'(SETTLE_CYC);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        if (settle_cnt != '0) settle_cnt <= settle_cnt - 1'b1;
        if (go) begin
          busy       <= 1'b1;
          cnt        <= len_of(op) - 1'b1;
          settle_cnt <= '0;
        end
      end
    end
  end

  assign settling = (settle_cnt != '0);

endmodule

// File: rtl/nws_toggle.sv
module nws_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic busy,
  input  logic ce_n,
  input  logic oe_n,
  output logic strobe,
  output logic tgl
);
  logic oe_q;

  assign strobe = oe_q && !oe_n && !ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q <= 1'b1;
      tgl  <= 1'b0;
    end else begin
      oe_q <= oe_n;
      if (go)                  tgl <= 1'b0;
      else if (busy && strobe) tgl <= ~tgl;
    end
  end

endmodule

// File: rtl/nws_readmux.sv
module nws_readmux
  import nws_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          busy,
  input  logic          settling,
  input  op_e           op,
  input  logic [DW-1:0] word,
  input  logic          tgl,
  input  logic [DW-1:0] array_q,
  output logic [DW-1:0] rd_q
);
  function automatic logic [DW-1:0] busy_word(input logic poll, input logic t);
    logic [DW-1:0] w;
    w    = '1;
    w[7] = poll;
    w[6] = t;
    return w;
  endfunction

  function automatic logic [DW-1:0] settle_word(input logic b7);
    logic [DW-1:0] w;
    w    = '1;
    w[7] = b7;
    return w;
  endfunction

  logic poll_bit;
  assign poll_bit = (op == OP_PROG) ? ~word[7] : 1'b0;

  always_comb begin
    if (busy)          rd_q = busy_word(poll_bit, tgl);
    else if (settling) rd_q = settle_word(array_q[7]);
    else               rd_q = array_q;
  end

endmodule

// File: rtl/nor_wstatus.sv
module nor_wstatus
  import nws_pkg::*;
#(
  parameter int          DW         = 16,
  parameter int unsigned PROG_CYC   = 24,
  parameter int unsigned SECT_CYC   = 60,
  parameter int unsigned BLK_CYC    = 75,
  parameter int unsigned CHIP_CYC   = 110,
  parameter int unsigned SETTLE_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_prog,
  input  logic [DW-1:0] prog_word,
  input  logic          start_erase,
  input  logic [1:0]    erase_kind,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [DW-1:0] array_q,
  output logic [DW-1:0] rd_q,
  output logic          busy,
  output logic          done
);
  logic          go;
  logic          settling;
  logic          strobe;
  logic          tgl;
  op_e           op_q;
  op_e           op_next;
  logic [DW-1:0] word_q;

  assign go      = !busy && (start_prog || start_erase);
  assign op_next = pick_op(start_prog, erase_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_PROG;
      word_q <= '0;
    end else if (go) begin
      op_q   <= op_next;
      word_q <= start_prog ? prog_word : '1;
    end
  end

  nws_timer #(
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .BLK_CYC(BLK_CYC),
    .CHIP_CYC(CHIP_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op_next),
    .busy(busy), .done(done), .settling(settling)
  );

  nws_toggle u_toggle (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy),
    .ce_n(ce_n), .oe_n(oe_n), .strobe(strobe), .tgl(tgl)
  );

  nws_readmux #(.DW(DW)) u_mux (
    .busy(busy), .settling(settling), .op(op_q), .word(word_q),
    .tgl(tgl), .array_q(array_q), .rd_q(rd_q)
  );

endmodule

// File: rtl/nws_chk.sv
module nws_chk
  import nws_pkg::*;
#(
  parameter int          DW         = 16,
  parameter int unsigned PROG_CYC   = 24,
  parameter int unsigned SECT_CYC   = 60,
  parameter int unsigned BLK_CYC    = 75,
  parameter int unsigned CHIP_CYC   = 110
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          busy,
  input logic          done,
  input logic          settling,
  input logic          strobe,
  input op_e           op_q,
  input logic [DW-1:0] word_q,
  input logic [DW-1:0] array_q,
  input logic [DW-1:0] rd_q
);
  localparam logic [DW-1:0] STAT_BITS  = DW'(8'hC0);
  localparam logic [DW-1:0] POLL_BIT   = DW'(8'h80);

  int unsigned run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_cnt <= 0;
    else if (go)   run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
  end

  function automatic int unsigned want_len(input op_e o);
    case (o)
      OP_PROG: return PROG_CYC;
      OP_SECT: return SECT_CYC;
      OP_BLK:  return BLK_CYC;
      default: return CHIP_CYC;
    endcase
  endfunction

  p_go_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_cnt == want_len(op_q));

  p_done_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  p_done_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_prog_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_PROG) |-> (rd_q[7] == ~word_q[7]));

  p_erase_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q != OP_PROG) |-> !rd_q[7]);

  p_tgl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(strobe)) |-> $stable(rd_q[6]));

  p_tgl_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(strobe)) |-> (rd_q[6] != $past(rd_q[6])));

  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (&(rd_q | STAT_BITS)));

  p_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    settling |-> ((rd_q[7] == array_q[7]) && (&(rd_q | POLL_BIT))));

  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !settling) |-> (rd_q == array_q));

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(word_q) && $stable(op_q)));

endmodule

bind nor_wstatus nws_chk #(
  .DW(DW), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
  .BLK_CYC(BLK_CYC), .CHIP_CYC(CHIP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
  .settling(settling), .strobe(strobe), .op_q(op_q), .word_q(word_q),
  .array_q(array_q), .rd_q(rd_q)
);

// File: tb/nor_wstatus_bench.sv
module nor_wstatus_bench;
  localparam int          DW     = 16;
  localparam int unsigned PROG   = 24;
  localparam int unsigned SECT   = 60;
  localparam int unsigned BLK    = 75;
  localparam int unsigned CHIP   = 110;
  localparam int unsigned SETTLE = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_prog = 1'b0;
  logic [DW-1:0] prog_word = '0;
  logic          start_erase = 1'b0;
  logic [1:0]    erase_kind = 2'd0;
  logic          ce_n = 1'b0;
  logic          oe_n = 1'b1;
  logic [DW-1:0] array_q = 16'h1234;
  logic [DW-1:0] rd_q;
  logic          busy;
  logic          done;

  int checks = 0;
  int failures = 0;
  int bcnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nor_wstatus #(
    .DW(DW), .PROG_CYC(PROG), .SECT_CYC(SECT), .BLK_CYC(BLK),
    .CHIP_CYC(CHIP), .SETTLE_CYC(SETTLE)
  ) u_nor_wstatus (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .prog_word(prog_word),
    .start_erase(start_erase), .erase_kind(erase_kind), .ce_n(ce_n), .oe_n(oe_n),
    .array_q(array_q), .rd_q(rd_q), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_busy(input bit prog, input logic [DW-1:0] w,
                                             input bit t);
    logic [DW-1:0] r = 16'hFFFF;
    r[7] = prog ? !w[7] : 1'b0;
    r[6] = t;
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_settle(input logic [DW-1:0] a);
    return {8'hFF, a[7], 7'h7F};
  endfunction

  function automatic int unsigned exp_len(input bit sp, input logic [1:0] ek);
    if (sp) return PROG;
    if (ek == 2'd0) return SECT;
    if (ek == 2'd1) return BLK;
    return CHIP;
  endfunction

  task automatic tk();
    @(negedge clk);
    if (busy) bcnt++;
  endtask

  task automatic run_op(input bit sp, input bit se, input logic [1:0] ek,
                        input logic [DW-1:0] w, input logic [DW-1:0] aq);
    bit prog = sp;
    int unsigned len = exp_len(sp, ek);
    array_q = aq;
    @(negedge clk);
    start_prog = sp; start_erase = se; erase_kind = ek; prog_word = w;
    bcnt = 0;
    tk();
    start_prog = 1'b0; start_erase = 1'b0;
    chk(busy === 1'b1, "R1 busy after start", busy, 1);
    chk(rd_q === exp_busy(prog, w, 1'b0), "R4/R5/R7 R6 initial status", rd_q, exp_busy(prog, w, 1'b0));
    oe_n = 1'b0;
    tk();
    chk(rd_q[6] === 1'b1, "R6 flip on strobe", rd_q[6], 1);
    oe_n = 1'b1;
    tk();
    chk(rd_q[6] === 1'b1, "R6 hold without strobe", rd_q[6], 1);
    ce_n = 1'b1; oe_n = 1'b0;
    tk();
    chk(rd_q[6] === 1'b1, "R6 deselected fall ignored", rd_q[6], 1);
    oe_n = 1'b1; ce_n = 1'b0;
    tk();
    oe_n = 1'b0;
    tk();
    chk(rd_q[6] === 1'b0, "R6 second flip", rd_q[6], 0);
    oe_n = 1'b1;
    start_prog = 1'b1; start_erase = 1'b1; erase_kind = ~ek; prog_word = ~w;
    tk();
    start_prog = 1'b0; start_erase = 1'b0;
    tk();
    chk(rd_q === exp_busy(prog, w, 1'b0), "R10 late start ignored", rd_q, exp_busy(prog, w, 1'b0));
    while (busy) tk();
    chk(bcnt == int'(len), "R2 R11 busy length", bcnt, len);
    chk(done === 1'b1, "R3 done pulse", done, 1);
    chk(rd_q === exp_settle(aq), "R8 settle start", rd_q, exp_settle(aq));
    tk();
    chk(done === 1'b0, "R3 done single", done, 0);
    for (int i = 2; i < int'(SETTLE); i++) tk();
    chk(rd_q === exp_settle(aq), "R8 settle last", rd_q, exp_settle(aq));
    tk();
    chk(rd_q === aq, "R9 pass after settle", rd_q, aq);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R12 reset flags", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_q === array_q, "R12 reset pass", rd_q, array_q);
    for (int i = 0; i < 4; i++) begin
      array_q = 16'($urandom);
      @(negedge clk);
      chk(rd_q === array_q, "R9 idle pass", rd_q, array_q);
    end
    run_op(1'b1, 1'b0, 2'd0, 16'h0080, 16'hFFFF);
    run_op(1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000);
    run_op(1'b0, 1'b1, 2'd0, 16'h0000, 16'hFFFF);
    run_op(1'b0, 1'b1, 2'd1, 16'h0000, 16'hFF7F);
    run_op(1'b0, 1'b1, 2'd2, 16'h0000, 16'hFFFF);
    run_op(1'b0, 1'b1, 2'd3, 16'h0000, 16'h0080);
    run_op(1'b1, 1'b1, 2'd2, 16'h5A5A, 16'h5A5A);
    for (int i = 0; i < 6; i++) begin
      bit sp = bit'($urandom % 2);
      run_op(sp, !sp, 2'($urandom), 16'($urandom), 16'($urandom));
    end
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule